// File: doc/BRIEF.md
# Register-Indexed Prefetch Result Buffer

This block holds the results of software-directed prefetches, one slot per general-purpose register. Register zero has no slot. When a prefetch stream is started for a register, the slot records the element data type and the sequence tag of the outstanding request, and is marked as waiting. The memory side later returns the data, or reports an access fault, against that register number and tag. The slot then becomes either filled or faulted.

The execution pipeline reads the buffer through a port indexed by register number:

- **Filled slot:** the read returns the stored value, extended to 32 bits as the latched data type directs. The same read also counts as issuing the next prefetch for that register, so the slot goes back to waiting under the new tag that the consumer supplies.
- **Waiting slot:** the read raises a stall until the data arrives. If the matching response arrives in the same cycle as the read, the data passes straight through.
- **Faulted slot:** the read raises a fault toward the control logic instead of data. Faults are therefore reported only when the value is actually used.

Top module: `pfb_buffer`

## Requirements
- R1: Slots exist for register numbers 1 to NUM_REGS-1. A read of register 0 completes at once with zero data. A start or a response addressed to register 0 changes nothing.
- R2: After reset every slot is filled with zero data and the word type. A read of any register then completes with data 0.
- R3: A start latches the type code and the request tag into the slot and makes it waiting. A read of a waiting slot, with no matching response in that cycle, gives stall=1, ready=0 and fault=0.
- R4: A response updates a slot only when the slot is waiting and the response tag equals the stored tag. The slot becomes filled with the response data, or faulted if the fault flag is set. Any other response is dropped.
- R5: Type codes select the extension of the stored low-order bits: 0 word; 1 halfword zero-extended; 2 halfword sign-extended; 3 byte zero-extended; 4 byte sign-extended. Codes 5 to 7 act as word.
- R6: A read of a faulted slot gives fault=1, ready=0 and stall=0. The slot stays faulted until a new start.
- R7: A completed read of slot n makes slot n waiting under the tag presented on the next-tag input. A repeated read then stalls.
- R8: When a read of a waiting slot coincides with its matching response, the read completes in that cycle with the response data, extended. The slot is then waiting under the next tag. If that response carries the fault flag, the read reports a fault instead.
- R9: A start to a slot takes priority over a same-cycle consume or response for that slot. The slot ends waiting under the start's tag and type.
- R10: With no read requested, ready, stall and fault are all 0. At most one of them is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start a prefetch stream on a register |
| start_reg | input | IDX_W | Register number for the start |
| start_dtype | input | 3 | Element type code (R5) |
| start_tag | input | TAG_W | Sequence tag of the first request |
| rsp_valid | input | 1 | A prefetch response is present |
| rsp_reg | input | IDX_W | Register number of the response |
| rsp_tag | input | TAG_W | Sequence tag of the response |
| rsp_data | input | 32 | Raw returned data |
| rsp_fault | input | 1 | The access faulted |
| rd_valid | input | 1 | Operand read request |
| rd_reg | input | IDX_W | Register number to read |
| rd_next_tag | input | TAG_W | Tag of the follow-on request issued by a completed read |
| rd_ready | output | 1 | Read completes this cycle |
| rd_stall | output | 1 | Data not yet available, consumer must wait |
| rd_fault | output | 1 | Deferred access fault on the read slot |
| rd_data | output | 32 | Extended operand, valid with rd_ready |

## Verification
A wrong slot state shows at the read port on the first read of that register. A lost waiting mark gives stale data where a stall is due. A tag mismatch that is accepted ends a stall too early, or with the wrong value. A lost fault hands data to the pipeline instead of an exception. Type or extension errors show only in the upper bits of rd_data, so the bench sweeps every register with type codes that rotate across registers, using data of both sign polarities. Each of these faults is visible in the same cycle as the read. Priority and bypass faults show on the read immediately after the colliding cycle.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        ST_DONE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_FAULT = 2'd2
    } pfb_state_e;

    typedef enum logic [2:0] {
        DT_WORD   = 3'd0,
        DT_HALF_U = 3'd1,
        DT_HALF_S = 3'd2,
        DT_BYTE_U = 3'd3,
        DT_BYTE_S = 3'd4
    } pfb_dtype_e;

    typedef struct packed {
        pfb_state_e      st;
        logic [2:0]      dt;
        logic [XLEN-1:0] data;
    } pfb_slot_t;

    localparam pfb_slot_t SLOT_RESET = '{st: ST_DONE, dt: 3'd0, data: '0};

    // Widen the low-order bits of a raw value according to the type code.
    function automatic logic [XLEN-1:0] pfb_extend(input logic [XLEN-1:0] raw,
                                                   input logic [2:0] dt);
        logic [XLEN-1:0] r;
        case (dt)
            DT_HALF_U: r = {{(XLEN-16){1'b0}}, raw[15:0]};
            DT_HALF_S: r = {{(XLEN-16){raw[15]}}, raw[15:0]};
            DT_BYTE_U: r = {{(XLEN-8){1'b0}}, raw[7:0]};
            DT_BYTE_S: r = {{(XLEN-8){raw[7]}}, raw[7:0]};
            default:   r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfb_slot_bank.sv
module pfb_slot_bank
    import pfb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_valid,
    input  logic [IDX_W-1:0]     start_reg,
    input  logic [2:0]           start_dtype,
    input  logic [TAG_W-1:0]     start_tag,
    input  logic                 use_fire,
    input  logic [IDX_W-1:0]     use_reg,
    input  logic [TAG_W-1:0]     use_tag,
    input  logic                 rsp_valid,
    input  logic [IDX_W-1:0]     rsp_reg,
    input  logic [TAG_W-1:0]     rsp_tag,
    input  logic [XLEN-1:0]      rsp_data,
    input  logic                 rsp_fault,
    output pfb_slot_t            slots [NUM_REGS],
    output logic [TAG_W-1:0]     tags  [NUM_REGS]
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == 0) begin : g_zero
            // Register zero never holds a prefetch.
            assign slots[g] = SLOT_RESET;
            assign tags[g]  = '0;
        end else begin : g_live
            pfb_slot_t        slot_q;
            logic [TAG_W-1:0] tag_q;
            logic             hit_start;
            logic             hit_use;
            logic             hit_rsp;

            always_comb begin
                hit_start = start_valid && (start_reg == IDX_W'(g));
                hit_use   = use_fire && (use_reg == IDX_W'(g));
                hit_rsp   = rsp_valid && (rsp_reg == IDX_W'(g))
                            && (slot_q.st == ST_PEND) && (rsp_tag == tag_q);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= SLOT_RESET;
                    tag_q  <= '0;
                end else if (hit_start) begin
                    slot_q.st <= ST_PEND;
                    slot_q.dt <= start_dtype;
                    tag_q     <= start_tag;
                end else if (hit_use) begin
                    slot_q.st <= ST_PEND;
                    tag_q     <= use_tag;
                end else if (hit_rsp) begin
                    slot_q.st   <= rsp_fault ? ST_FAULT : ST_DONE;
                    slot_q.data <= rsp_data;
                end
            end

            assign slots[g] = slot_q;
            assign tags[g]  = tag_q;
        end
    end

endmodule

// File: rtl/pfb_read_port.sv
module pfb_read_port
    import pfb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  pfb_slot_t            slots [NUM_REGS],
    input  logic [TAG_W-1:0]     tags  [NUM_REGS],
    input  logic                 rd_valid,
    input  logic [IDX_W-1:0]     rd_reg,
    input  logic                 rsp_valid,
    input  logic [IDX_W-1:0]     rsp_reg,
    input  logic [TAG_W-1:0]     rsp_tag,
    input  logic [XLEN-1:0]      rsp_data,
    input  logic                 rsp_fault,
    output logic                 rd_ready,
    output logic                 rd_stall,
    output logic                 rd_fault,
    output logic [XLEN-1:0]      rd_data,
    output logic                 use_fire
);

    pfb_slot_t        sel;
    logic [TAG_W-1:0] sel_tag;
    logic             bypass;

    always_comb begin
        sel      = slots[rd_reg];
        sel_tag  = tags[rd_reg];
        bypass   = rsp_valid && (rsp_reg == rd_reg)
                   && (sel.st == ST_PEND) && (rsp_tag == sel_tag);
        rd_ready = 1'b0;
        rd_stall = 1'b0;
        rd_fault = 1'b0;
        rd_data  = '0;
        if (rd_valid) begin
            if (rd_reg == '0) begin
                rd_ready = 1'b1;
            end else begin
                case (sel.st)
                    ST_DONE: begin
                        rd_ready = 1'b1;
                        rd_data  = pfb_extend(sel.data, sel.dt);
                    end
                    ST_FAULT: rd_fault = 1'b1;
                    default: begin
                        if (bypass && rsp_fault) begin
                            rd_fault = 1'b1;
                        end else if (bypass) begin
                            rd_ready = 1'b1;
                            rd_data  = pfb_extend(rsp_data, sel.dt);
                        end else begin
                            rd_stall = 1'b1;
                        end
                    end
                endcase
            end
        end
        use_fire = rd_ready && (rd_reg != '0);
    end

endmodule

// File: rtl/pfb_buffer.sv
module pfb_buffer
    import pfb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    input  logic [IDX_W-1:0] start_reg,
    input  logic [2:0]       start_dtype,
    input  logic [TAG_W-1:0] start_tag,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_reg,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [31:0]      rsp_data,
    input  logic             rsp_fault,
    input  logic             rd_valid,
    input  logic [IDX_W-1:0] rd_reg,
    input  logic [TAG_W-1:0] rd_next_tag,
    output logic             rd_ready,
    output logic             rd_stall,
    output logic             rd_fault,
    output logic [31:0]      rd_data
);

    pfb_slot_t        slots [NUM_REGS];
    logic [TAG_W-1:0] tags  [NUM_REGS];
    logic             use_fire;

    pfb_slot_bank #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .start_reg   (start_reg),
        .start_dtype (start_dtype),
        .start_tag   (start_tag),
        .use_fire    (use_fire),
        .use_reg     (rd_reg),
        .use_tag     (rd_next_tag),
        .rsp_valid   (rsp_valid),
        .rsp_reg     (rsp_reg),
        .rsp_tag     (rsp_tag),
        .rsp_data    (rsp_data),
        .rsp_fault   (rsp_fault),
        .slots       (slots),
        .tags        (tags)
    );

    pfb_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_rd (
        .slots     (slots),
        .tags      (tags),
        .rd_valid  (rd_valid),
        .rd_reg    (rd_reg),
        .rsp_valid (rsp_valid),
        .rsp_reg   (rsp_reg),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data),
        .rsp_fault (rsp_fault),
        .rd_ready  (rd_ready),
        .rd_stall  (rd_stall),
        .rd_fault  (rd_fault),
        .rd_data   (rd_data),
        .use_fire  (use_fire)
    );

endmodule

// File: rtl/pfb_buffer_chk.sv
module pfb_buffer_chk #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_valid,
    input logic [IDX_W-1:0] start_reg,
    input logic             rsp_valid,
    input logic [IDX_W-1:0] rsp_reg,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_reg,
    input logic             rd_ready,
    input logic             rd_stall,
    input logic             rd_fault,
    input logic [31:0]      rd_data
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !(rd_ready || rd_stall || rd_fault)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_ready, rd_stall, rd_fault})); // R10

    AST_REG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_reg == '0) |-> (rd_ready && rd_data == 32'd0)); // R1

    AST_START_WAITS: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_reg != '0) |=>
        (!(rd_valid && rd_reg == $past(start_reg) && !(rsp_valid && rsp_reg == rd_reg))
         || rd_stall)); // R3

    AST_USE_REPENDS: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && rd_reg != '0) |=>
        (!(rd_valid && rd_reg == $past(rd_reg) && !(rsp_valid && rsp_reg == rd_reg))
         || rd_stall)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_fault && !(start_valid && start_reg == rd_reg)) |=>
        (!(rd_valid && rd_reg == $past(rd_reg)) || rd_fault)); // R6

endmodule

bind pfb_buffer pfb_buffer_chk #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_reg   (start_reg),
    .rsp_valid   (rsp_valid),
    .rsp_reg     (rsp_reg),
    .rd_valid    (rd_valid),
    .rd_reg      (rd_reg),
    .rd_ready    (rd_ready),
    .rd_stall    (rd_stall),
    .rd_fault    (rd_fault),
    .rd_data     (rd_data)
);

// File: tb/pfb_buffer_bench.sv
`timescale 1ns/1ps
module pfb_buffer_bench;

    localparam int K_IDLE = 0;
    localparam int K_RDY  = 1;
    localparam int K_STL  = 2;
    localparam int K_FLT  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic [4:0]  start_reg = '0;
    logic [2:0]  start_dtype = '0;
    logic [3:0]  start_tag = '0;
    logic        rsp_valid = 1'b0;
    logic [4:0]  rsp_reg = '0;
    logic [3:0]  rsp_tag = '0;
    logic [31:0] rsp_data = '0;
    logic        rsp_fault = 1'b0;
    logic        rd_valid = 1'b0;
    logic [4:0]  rd_reg = '0;
    logic [3:0]  rd_next_tag = '0;
    logic        rd_ready;
    logic        rd_stall;
    logic        rd_fault;
    logic [31:0] rd_data;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pfb_buffer u_pfb_buffer (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_reg(start_reg),
        .start_dtype(start_dtype), .start_tag(start_tag),
        .rsp_valid(rsp_valid), .rsp_reg(rsp_reg), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .rd_valid(rd_valid), .rd_reg(rd_reg), .rd_next_tag(rd_next_tag),
        .rd_ready(rd_ready), .rd_stall(rd_stall), .rd_fault(rd_fault),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] ref_ext(input logic [31:0] x, input int d);
        case (d)
            1: return x & 32'h0000_FFFF;
            2: return x[15] ? (x | 32'hFFFF_0000) : (x & 32'h0000_FFFF);
            3: return x & 32'h0000_00FF;
            4: return x[7] ? (x | 32'hFFFF_FF00) : (x & 32'h0000_00FF);
            default: return x;
        endcase
    endfunction

    // Drive one cycle of stimulus after the falling edge, then check the
    // combinational read outcome before the next rising edge.
    task automatic step(input logic sv, input logic [4:0] sr, input logic [2:0] sd,
                        input logic [3:0] st,
                        input logic pv, input logic [4:0] pr, input logic [3:0] pt,
                        input logic [31:0] pd, input logic pf,
                        input logic rv, input logic [4:0] rr, input logic [3:0] rn,
                        input int kind, input logic [31:0] ed, input string req);
        logic [2:0] exp_flags;
        logic [2:0] got_flags;
        @(negedge clk);
        start_valid = sv; start_reg = sr; start_dtype = sd; start_tag = st;
        rsp_valid = pv; rsp_reg = pr; rsp_tag = pt; rsp_data = pd; rsp_fault = pf;
        rd_valid = rv; rd_reg = rr; rd_next_tag = rn;
        #2;
        case (kind)
            K_RDY:   exp_flags = 3'b100;
            K_STL:   exp_flags = 3'b010;
            K_FLT:   exp_flags = 3'b001;
            default: exp_flags = 3'b000;
        endcase
        got_flags = {rd_ready, rd_stall, rd_fault};
        vectors++;
        if (got_flags !== exp_flags || (kind == K_RDY && rd_data !== ed)) begin
            misses++;
            $display("FAIL %s reg=%0d flags(rdy,stl,flt) got=%b exp=%b data got=%h exp=%h",
                     req, rr, got_flags, exp_flags, rd_data, ed);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset contents, every register including zero (R1)
        for (int r = 0; r < 32; r++)
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),4'd0, K_RDY, 32'd0, "R2 reset read");

        // R1: register zero ignores starts and responses
        step(1,5'd0,3'd1,4'd3, 1,5'd0,4'd3,32'hDEAD_BEEF,1'b0, 0,0,0, K_IDLE, 0, "R10 idle");
        step(0,0,0,0, 0,0,0,0,0, 1,5'd0,4'd0, K_RDY, 32'd0, "R1 reg zero");

        for (int r = 1; r < 32; r++) begin
            int          d  = r % 5;
            logic [3:0]  ta = 4'(r);
            logic [3:0]  tb = 4'(r + 5);
            logic [3:0]  tc = 4'(r + 9);
            logic [31:0] p1 = 32'(r) * 32'h9E37_79B1;
            logic [31:0] p2 = ~p1;
            step(1,5'(r),3'(d),ta, 0,0,0,0,0, 0,0,0, K_IDLE, 0, "R10 no read");
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),0, K_STL, 0, "R3 waiting stall");
            step(0,0,0,0, 1,5'(r),ta^4'd1,p1,0, 1,5'(r),0, K_STL, 0, "R4 tag mismatch dropped");
            step(0,0,0,0, 1,5'(r),ta,p1,0, 0,0,0, K_IDLE, 0, "R10 no read");
            step(0,0,0,0, 1,5'(r),ta,p2,0, 1,5'(r),tb, K_RDY, ref_ext(p1,d), "R5 extend / R4 filled drop");
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),0, K_STL, 0, "R7 consume repends");
            step(0,0,0,0, 1,5'(r),tb,p2,0, 1,5'(r),tc, K_RDY, ref_ext(p2,d), "R8 bypass");
            step(0,0,0,0, 1,5'(r),tc,32'h0,1, 0,0,0, K_IDLE, 0, "R10 no read");
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),0, K_FLT, 0, "R6 fault read");
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),0, K_FLT, 0, "R6 fault sticky");
            step(1,5'(r),3'd0,ta, 0,0,0,0,0, 0,0,0, K_IDLE, 0, "R10 no read");
            step(0,0,0,0, 1,5'(r),ta,p1,0, 0,0,0, K_IDLE, 0, "R10 no read");
            step(1,5'(r),3'(d),tc, 0,0,0,0,0, 1,5'(r),tb, K_RDY, p1, "R9 read with start");
            step(0,0,0,0, 1,5'(r),tb,p2,0, 1,5'(r),0, K_STL, 0, "R9 start tag wins");
            step(0,0,0,0, 1,5'(r),tc,p2,0, 0,0,0, K_IDLE, 0, "R10 no read");
            step(0,0,0,0, 0,0,0,0,0, 1,5'(r),0, K_RDY, ref_ext(p2,d), "R9 start type wins");
        end

        // R8: same-cycle fault response on a read reports a fault
        step(1,5'd7,3'd0,4'd2, 0,0,0,0,0, 0,0,0, K_IDLE, 0, "R10 no read");
        step(0,0,0,0, 1,5'd7,4'd2,32'h1234,1, 1,5'd7,4'd4, K_FLT, 0, "R8 bypass fault");
        step(0,0,0,0, 0,0,0,0,0, 1,5'd7,0, K_FLT, 0, "R6 fault after bypass");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule